// File: doc/BRIEF.md
# Status-Decoding Bus Command Generator

This block sits beside a processor that does not drive its own bus strobes. The processor announces each bus cycle with a 3-bit status code. The code sits at an all-ones passive value between cycles. The generator samples that code on every clock and detects a new cycle when the code leaves the passive value. It then pulses the address strobe for one clock and asserts the matching active-low command strobe on the next clock. It holds that strobe until the code returns to passive.

Along with the strobes, the block drives a transceiver enable and a transceiver direction line, so that external data buffers point the right way for the whole cycle. A code that changes from one non-passive value to another without passing through passive does not start a new cycle. A non-passive code seen after reset is also ignored until passive has been observed once.

Top module: `buscmd_gen`

## Requirements
- R1: While reset is asserted and after it is released, with no cycle in progress: address strobe low, transceiver enable low, direction high, and all five command strobes high (inactive).
- R2: When the sampled status is 111 on one clock edge and a different code on the next, the address strobe is high for exactly the one clock that follows that second edge.
- R3: The command strobe goes low in the clock right after the address strobe. It stays low while the sampled status is not 111. It returns high in the clock after the edge that samples 111.
- R4: Code decoding: 100 (fetch) and 101 both drive the memory-read strobe, 110 memory-write, 001 I/O-read, 010 I/O-write, 000 interrupt-acknowledge; at most one strobe is low at any time.
- R5: Code 011 (halt) pulses the address strobe but asserts no command strobe and leaves the transceiver enable low.
- R6: The transceiver enable is high in exactly the clocks in which a command strobe is low.
- R7: Direction is low from the address-strobe clock until release for fetch, memory-read, I/O-read and interrupt-acknowledge cycles. It is high during write and halt cycles and between cycles.
- R8: A status change from one non-passive code to another during a cycle is ignored: the original strobe and direction are kept until 111 is sampled.
- R9: After reset, a non-passive status produces no address strobe and no command until 111 has been sampled at least once.
- R10: If 111 is sampled on the edge that ends the address-strobe clock, the cycle is dropped: no command strobe follows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cpu_stat_i | input | 3 | Processor bus status code |
| addr_stb_o | output | 1 | Address latch strobe, one clock per cycle |
| xcvr_en_o | output | 1 | Data transceiver enable, active high |
| xcvr_dir_o | output | 1 | Transceiver direction: 1 transmit (write), 0 receive (read) |
| mem_rd_n_o | output | 1 | Memory read command, active low |
| mem_wr_n_o | output | 1 | Memory write command, active low |
| io_rd_n_o | output | 1 | I/O read command, active low |
| io_wr_n_o | output | 1 | I/O write command, active low |
| irq_ack_n_o | output | 1 | Interrupt acknowledge command, active low |

## Verification
The assertions check on every clock that the address strobe is a single-clock pulse preceded by a passive code, and that no more than one command is low. They also check that a command only begins right after the address strobe, is held stable until passive returns and is dropped after that. The enable tracks the command, and direction agrees with read or write strobes. The bench scenarios cover the rest: the exact code-to-strobe mapping for all eight codes, the halt case without a strobe, and the dropped cycle when passive returns early. They also show that mid-cycle code changes are ignored and that a non-passive status right out of reset is ignored.

// File: rtl/buscmd_pkg.sv
package buscmd_pkg;

    localparam int STAT_W = 3;
    localparam int NCMD   = 5;

    localparam logic [STAT_W-1:0] CODE_INTA  = 3'b000;
    localparam logic [STAT_W-1:0] CODE_IORD  = 3'b001;
    localparam logic [STAT_W-1:0] CODE_IOWR  = 3'b010;
    localparam logic [STAT_W-1:0] CODE_HALT  = 3'b011;
    localparam logic [STAT_W-1:0] CODE_FETCH = 3'b100;
    localparam logic [STAT_W-1:0] CODE_MRD   = 3'b101;
    localparam logic [STAT_W-1:0] CODE_MWR   = 3'b110;
    localparam logic [STAT_W-1:0] CODE_IDLE  = 3'b111;

    localparam int SEL_MRD  = 0;
    localparam int SEL_MWR  = 1;
    localparam int SEL_IORD = 2;
    localparam int SEL_IOWR = 3;
    localparam int SEL_INTA = 4;

    typedef enum logic [1:0] {
        SQ_WAIT = 2'd0,
        SQ_IDLE = 2'd1,
        SQ_ADDR = 2'd2,
        SQ_CMD  = 2'd3
    } seq_e;

    typedef struct packed {
        seq_e              st;
        logic [STAT_W-1:0] kind;
    } seq_s;

    typedef struct packed {
        logic            ale;
        logic            en;
        logic            dir;
        logic [NCMD-1:0] cmd_n;
    } drv_s;

endpackage

// File: rtl/buscmd_decode.sv
module buscmd_decode
    import buscmd_pkg::*;
(
    input  logic [STAT_W-1:0] code_i,
    output logic [NCMD-1:0]   sel_o,
    output logic              rd_o
);

    always_comb begin
        sel_o = '0;
        rd_o  = 1'b0;
        unique case (code_i)
            CODE_INTA: begin
                sel_o[SEL_INTA] = 1'b1;
                rd_o            = 1'b1;
            end
            CODE_IORD: begin
                sel_o[SEL_IORD] = 1'b1;
                rd_o            = 1'b1;
            end
            CODE_IOWR: begin
                sel_o[SEL_IOWR] = 1'b1;
            end
            CODE_FETCH, CODE_MRD: begin
                sel_o[SEL_MRD] = 1'b1;
                rd_o           = 1'b1;
            end
            CODE_MWR: begin
                sel_o[SEL_MWR] = 1'b1;
            end
            default: begin
                sel_o = '0;
                rd_o  = 1'b0;
            end
        endcase
    end

endmodule

// File: rtl/buscmd_seq.sv
module buscmd_seq
    import buscmd_pkg::*;
(
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic [STAT_W-1:0] stat_i,
    output seq_s              nxt_o
);

    seq_s seq_d, seq_q;
    logic passive;

    assign passive = (stat_i == CODE_IDLE);

    always_comb begin
        seq_d = seq_q;
        unique case (seq_q.st)
            SQ_WAIT: begin
                if (passive) seq_d.st = SQ_IDLE;
            end
            SQ_IDLE: begin
                if (!passive) begin
                    seq_d.st   = SQ_ADDR;
                    seq_d.kind = stat_i;
                end
            end
            SQ_ADDR: begin
                seq_d.st = passive ? SQ_IDLE : SQ_CMD;
            end
            SQ_CMD: begin
                if (passive) seq_d.st = SQ_IDLE;
            end
            default: seq_d.st = SQ_WAIT;
        endcase
        if (seq_d.st == SQ_IDLE) seq_d.kind = CODE_IDLE;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            seq_q.st   <= SQ_WAIT;
            seq_q.kind <= CODE_IDLE;
        end else begin
            seq_q <= seq_d;
        end
    end

    assign nxt_o = seq_d;

endmodule

// File: rtl/buscmd_drive.sv
module buscmd_drive
    import buscmd_pkg::*;
(
    input  logic            clk_i,
    input  logic            rst_ni,
    input  seq_e            st_i,
    input  logic [NCMD-1:0] sel_i,
    input  logic            rd_i,
    output drv_s            drv_o
);

    drv_s drv_d, drv_q;
    logic [NCMD-1:0] cmd_n_d;
    logic in_cyc, in_cmd;

    assign in_cyc = (st_i == SQ_ADDR) || (st_i == SQ_CMD);
    assign in_cmd = (st_i == SQ_CMD);

    for (genvar g = 0; g < NCMD; g++) begin : g_strobe
        assign cmd_n_d[g] = ~(in_cmd & sel_i[g]);
    end

    always_comb begin
        drv_d       = drv_q;
        drv_d.ale   = (st_i == SQ_ADDR);
        drv_d.cmd_n = cmd_n_d;
        drv_d.en    = in_cmd & (|sel_i);
        drv_d.dir   = ~(in_cyc & rd_i);
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            drv_q.ale   <= 1'b0;
            drv_q.en    <= 1'b0;
            drv_q.dir   <= 1'b1;
            drv_q.cmd_n <= '1;
        end else begin
            drv_q <= drv_d;
        end
    end

    assign drv_o = drv_q;

endmodule

// File: rtl/buscmd_gen.sv
module buscmd_gen
    import buscmd_pkg::*;
(
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic [STAT_W-1:0] cpu_stat_i,
    output logic              addr_stb_o,
    output logic              xcvr_en_o,
    output logic              xcvr_dir_o,
    output logic              mem_rd_n_o,
    output logic              mem_wr_n_o,
    output logic              io_rd_n_o,
    output logic              io_wr_n_o,
    output logic              irq_ack_n_o
);

    seq_s            nxt;
    logic [NCMD-1:0] sel;
    logic            rd;
    drv_s            drv;

    buscmd_seq u_seq (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .stat_i (cpu_stat_i),
        .nxt_o  (nxt)
    );

    buscmd_decode u_dec (
        .code_i (nxt.kind),
        .sel_o  (sel),
        .rd_o   (rd)
    );

    buscmd_drive u_drv (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .st_i   (nxt.st),
        .sel_i  (sel),
        .rd_i   (rd),
        .drv_o  (drv)
    );

    assign addr_stb_o  = drv.ale;
    assign xcvr_en_o   = drv.en;
    assign xcvr_dir_o  = drv.dir;
    assign mem_rd_n_o  = drv.cmd_n[SEL_MRD];
    assign mem_wr_n_o  = drv.cmd_n[SEL_MWR];
    assign io_rd_n_o   = drv.cmd_n[SEL_IORD];
    assign io_wr_n_o   = drv.cmd_n[SEL_IOWR];
    assign irq_ack_n_o = drv.cmd_n[SEL_INTA];

endmodule

// File: rtl/buscmd_gen_chk.sv
module buscmd_gen_chk (
    input logic       clk_i,
    input logic       rst_ni,
    input logic [2:0] cpu_stat_i,
    input logic       addr_stb_o,
    input logic       xcvr_en_o,
    input logic       xcvr_dir_o,
    input logic       mem_rd_n_o,
    input logic       mem_wr_n_o,
    input logic       io_rd_n_o,
    input logic       io_wr_n_o,
    input logic       irq_ack_n_o
);

    logic [4:0] cmds;
    logic       cmd_act;

    assign cmds    = {irq_ack_n_o, io_wr_n_o, io_rd_n_o, mem_wr_n_o, mem_rd_n_o};
    assign cmd_act = ~(&cmds);

    AST_ALE_SINGLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
        addr_stb_o |=> !addr_stb_o); // R2

    AST_ALE_FROM_PASSIVE: assert property (@(posedge clk_i) disable iff (!rst_ni)
        addr_stb_o |-> ($past(cpu_stat_i) != 3'b111 && $past(cpu_stat_i, 2) == 3'b111)); // R2

    AST_ONE_STROBE: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $onehot0(~cmds)); // R4

    AST_CMD_AFTER_ALE: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(cmd_act) |-> $past(addr_stb_o)); // R3

    AST_CMD_RELEASE: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (cmd_act && cpu_stat_i == 3'b111) |=> !cmd_act); // R3

    AST_CMD_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (cmd_act && cpu_stat_i != 3'b111) |=> $stable(cmds)); // R8

    AST_EN_TRACKS: assert property (@(posedge clk_i) disable iff (!rst_ni)
        xcvr_en_o == cmd_act); // R6

    AST_WRITE_DIR: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!mem_wr_n_o || !io_wr_n_o) |-> xcvr_dir_o); // R7

    AST_READ_DIR: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!mem_rd_n_o || !io_rd_n_o || !irq_ack_n_o) |-> !xcvr_dir_o); // R7

endmodule

bind buscmd_gen buscmd_gen_chk u_chk (.*);

// File: tb/tb_buscmd_gen.sv
`timescale 1ns/1ps
module tb_buscmd_gen;

    logic       clk_i = 1'b0;
    logic       rst_ni = 1'b0;
    logic [2:0] cpu_stat_i = 3'b000;
    logic addr_stb_o, xcvr_en_o, xcvr_dir_o;
    logic mem_rd_n_o, mem_wr_n_o, io_rd_n_o, io_wr_n_o, irq_ack_n_o;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #2.5 clk_i = ~clk_i;

    buscmd_gen dut (.*);

    // vector: {ale, en, dir, mrd_n, mwr_n, iord_n, iowr_n, inta_n}
    localparam logic [7:0] IDLE_V = 8'b0_0_1_11111;

    function automatic logic [4:0] strobe_mask(input logic [2:0] c);
        case (c)
            3'b100, 3'b101: return 5'b01111;
            3'b110:         return 5'b10111;
            3'b001:         return 5'b11011;
            3'b010:         return 5'b11101;
            3'b000:         return 5'b11110;
            default:        return 5'b11111;
        endcase
    endfunction

    function automatic logic is_rd(input logic [2:0] c);
        return (c == 3'b000) || (c == 3'b001) || (c == 3'b100) || (c == 3'b101);
    endfunction

    function automatic logic [7:0] ale_v(input logic [2:0] c);
        return {1'b1, 1'b0, ~is_rd(c), 5'b11111};
    endfunction

    function automatic logic [7:0] cmd_v(input logic [2:0] c);
        logic [4:0] m;
        m = strobe_mask(c);
        return {1'b0, ~(&m), ~is_rd(c), m};
    endfunction

    function automatic logic [7:0] outs();
        return {addr_stb_o, xcvr_en_o, xcvr_dir_o, mem_rd_n_o, mem_wr_n_o,
                io_rd_n_o, io_wr_n_o, irq_ack_n_o};
    endfunction

    task automatic chk(input logic [7:0] exp, input string tag);
        logic [7:0] act;
        act = outs();
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%b expected=%b", tag, act, exp);
        end
    endtask

    // one full cycle: code held for ncmd command clocks, then passive
    task automatic run_cycle(input logic [2:0] c, input int ncmd, input string tag);
        cpu_stat_i = c;
        @(negedge clk_i);
        chk(ale_v(c), {tag, " R2 R7 ale"});
        for (int i = 0; i < ncmd; i++) begin
            @(negedge clk_i);
            chk(cmd_v(c), {tag, " R3 R4 R6 cmd"});
        end
        cpu_stat_i = 3'b111;
        @(negedge clk_i);
        chk(IDLE_V, {tag, " R3 release"});
    endtask

    task automatic t_reset();
        rst_ni = 1'b0;
        cpu_stat_i = 3'b000;
        repeat (3) @(negedge clk_i);
        chk(IDLE_V, "R1 during reset");
        rst_ni = 1'b1;
        repeat (4) @(negedge clk_i);
        chk(IDLE_V, "R9 non-passive after reset ignored");
        cpu_stat_i = 3'b101;
        repeat (2) @(negedge clk_i);
        chk(IDLE_V, "R9 code change without passive ignored");
        cpu_stat_i = 3'b111;
        repeat (2) @(negedge clk_i);
        chk(IDLE_V, "R1 idle after passive");
    endtask

    task automatic t_all_codes();
        run_cycle(3'b101, 3, "R4 memrd");
        run_cycle(3'b100, 1, "R4 fetch");
        run_cycle(3'b110, 2, "R4 memwr");
        run_cycle(3'b001, 2, "R4 iord");
        run_cycle(3'b010, 4, "R4 iowr");
        run_cycle(3'b000, 2, "R4 inta");
    endtask

    task automatic t_halt();
        run_cycle(3'b011, 3, "R5 halt");
    endtask

    task automatic t_midchange();
        cpu_stat_i = 3'b101;
        @(negedge clk_i);
        chk(ale_v(3'b101), "R8 ale");
        @(negedge clk_i);
        chk(cmd_v(3'b101), "R8 cmd");
        cpu_stat_i = 3'b010;
        repeat (2) @(negedge clk_i);
        chk(cmd_v(3'b101), "R8 change ignored");
        cpu_stat_i = 3'b110;
        @(negedge clk_i);
        chk(cmd_v(3'b101), "R8 second change ignored");
        cpu_stat_i = 3'b111;
        @(negedge clk_i);
        chk(IDLE_V, "R8 release");
    endtask

    task automatic t_abort();
        cpu_stat_i = 3'b110;
        @(negedge clk_i);
        chk(ale_v(3'b110), "R10 ale");
        cpu_stat_i = 3'b111;
        @(negedge clk_i);
        chk(IDLE_V, "R10 dropped cycle");
        @(negedge clk_i);
        chk(IDLE_V, "R10 still idle");
    endtask

    task automatic t_back_to_back();
        run_cycle(3'b001, 1, "R2 b2b first");
        run_cycle(3'b110, 1, "R2 b2b second");
        @(negedge clk_i);
        chk(IDLE_V, "R1 idle between cycles");
    endtask

    initial begin
        @(negedge clk_i);
        t_reset();
        t_all_codes();
        t_halt();
        t_midchange();
        t_abort();
        t_back_to_back();
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk_i);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

endmodule